// File: doc/BRIEF.md
# Per-Channel Idle Code Inserter

This block keeps a 64-entry table of 8-bit idle codes and writes selected codes over timeslots of a bit-serial transmit stream. Entries 0 to 31 are the transmit bank and entries 32 to 63 are the receive bank. The receive bank is stored and can be read back, but it has no other use in this block. A host reaches the table through a byte-wide register port. A control register holds a 6-bit pointer and two broadcast flags. A data register reaches the entry that the pointer selects. Four enable registers hold one bit per transmit channel.

The transmit stream comes in one bit per clock. A frame sync pulse marks the first bit of each frame. The block counts bit positions and works out which timeslot each bit belongs to. In E1 mode a frame is 32 timeslots of 8 bits, 256 bits in all. In T1 mode a frame is one framing bit followed by 24 timeslots, 193 bits in all. In each enabled timeslot the stored code goes out most significant bit first in place of the incoming byte. All other bits pass through. The output is registered.

Top module: `idle_code_inserter`

## Requirements
- R1: After reset, every register reads 0 and `tx_out` is 0. This covers the control register at 7Eh, the table entries read through 7Fh, and the enable registers at 80h to 83h.
- R2: Bits 5:0 of the control register (7Eh) form the table pointer. Pointer values 0 to 31 select transmit entries and 32 to 63 select receive entries. With both flags clear, a write to 7Fh stores the byte in the selected entry, and a read of 7Fh returns that entry. A read of 7Eh returns the control byte.
- R3: When control bit 6 is set, a write to 7Fh loads the byte into all 32 transmit entries and leaves the receive entries unchanged.
- R4: When control bit 7 is set, a write to 7Fh loads the byte into all 32 receive entries and leaves the transmit entries unchanged.
- R5: Enable register 80h+g holds channels 8g+1 to 8g+8 (g = 0 to 3). Bit k of that register enables channel 8g+k+1. These registers read back as written.
- R6: In the timeslot of an enabled channel n, the output bits are transmit entry n-1 sent MSB first (bit 7 down to bit 0). The timeslots of disabled channels pass the input through unchanged.
- R7: E1 mode (`e1_mode`=1): the bit with `fsync` high is frame bit 0. Bits 8t to 8t+7 form timeslot t, which is channel t+1. After bit 255 the count wraps to bit 0 even if no `fsync` arrives.
- R8: T1 mode: frame bit 0 is the framing bit and always passes through. Bits 8t+1 to 8t+8 form timeslot t, for t = 0 to 23. After bit 192 the count wraps. Enable bits for channels 25 to 32 have no effect.
- R9: `tx_out` shows the result for the input bit exactly one clock after that bit is presented.
- R10: A code or enable write that lands inside a timeslot changes nothing until the next timeslot boundary. The timeslot already under way goes out entirely with the values that held at its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one stream bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| e1_mode | input | 1 | 1 selects the 32-slot frame, 0 selects the 24-slot frame with framing bit |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| fsync | input | 1 | High on the first bit of a frame |
| tx_in | input | 1 | Incoming transmit bit |
| tx_out | output | 1 | Outgoing transmit bit, one clock later |

## Verification
The hardest case to reach is a host write that arrives in the middle of a timeslot that is already being replaced. It can only be tested if the write lands on a known bit of a known slot. To do this, the bench issues the write from inside its frame-driving loop, on a chosen bit position. Its shadow table changes only after the expected bit for that cycle has been worked out, so the expected output uses the old value for the rest of the slot. Other sweeps cover full E1 and T1 frames with mixed enable patterns, a second frame that runs without sync, and broadcast loads followed by a read of all 64 entries.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int CODE_W  = 8;
  localparam int SLOTS   = 32;
  localparam int T1_SLOTS = 24;
  localparam int PTR_W   = 6;
  localparam int POS_W   = 9;
  localparam int SLOT_W  = 5;
  localparam int BIT_W   = 3;
  localparam int ENTRIES = 2 * SLOTS;
  localparam int EN_REGS = SLOTS / CODE_W;

  typedef struct packed {
    logic              valid;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitn;
  } slot_loc_t;

  // Last bit index of a frame in either mode.
  function automatic logic [POS_W-1:0] frame_last(input logic e1);
    return e1 ? POS_W'(SLOTS * CODE_W - 1) : POS_W'(T1_SLOTS * CODE_W);
  endfunction

  // Map a bit position to its timeslot and bit within the slot.
  function automatic slot_loc_t locate(input logic [POS_W-1:0] pos, input logic e1);
    logic [POS_W-1:0] rel;
    slot_loc_t r;
    rel     = e1 ? pos : pos - POS_W'(1);
    r.valid = e1 || (pos != '0);
    r.slot  = rel[BIT_W +: SLOT_W];
    r.bitn  = rel[BIT_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
#(
  parameter logic [7:0] ADDR_BASE = 8'h7E
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           host_we,
  input  logic [7:0]                     host_addr,
  input  logic [CODE_W-1:0]              host_wdata,
  output logic [CODE_W-1:0]              host_rdata,
  output logic [SLOTS-1:0][CODE_W-1:0]   tx_codes,
  output logic [SLOTS-1:0]               tx_enables
);
  localparam logic [7:0] A_CTL  = ADDR_BASE;
  localparam logic [7:0] A_DATA = ADDR_BASE + 8'd1;
  localparam logic [7:0] A_EN   = ADDR_BASE + 8'd2;

  logic [7:0]                      ctl_q;
  logic [ENTRIES-1:0][CODE_W-1:0]  mem_q;
  logic [EN_REGS-1:0][CODE_W-1:0]  en_q;

  wire [PTR_W-1:0] ptr      = ctl_q[PTR_W-1:0];
  wire             bc_tx    = ctl_q[6];
  wire             bc_rx    = ctl_q[7];
  wire             data_we  = host_we && (host_addr == A_DATA);
  wire             en_hit   = (host_addr >= A_EN) && (host_addr < A_EN + 8'(EN_REGS));
  wire [7:0]       en_off   = host_addr - A_EN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      mem_q <= '0;
      en_q  <= '0;
    end else if (host_we) begin
      if (host_addr == A_CTL) ctl_q <= host_wdata;
      if (data_we) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if ((i < SLOTS && bc_tx) || (i >= SLOTS && bc_rx) ||
              (!bc_tx && !bc_rx && ptr == PTR_W'(i)))
            mem_q[i] <= host_wdata;
        end
      end
      if (en_hit) en_q[en_off[1:0]] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == A_CTL)       host_rdata = ctl_q;
    else if (host_addr == A_DATA) host_rdata = mem_q[ptr];
    else if (en_hit)              host_rdata = en_q[en_off[1:0]];
  end

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_tx
      assign tx_codes[s]   = mem_q[s];
      assign tx_enables[s] = en_q[s / CODE_W][s % CODE_W];
    end
  endgenerate
endmodule

// File: rtl/icu_framer.sv
module icu_framer
  import icu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e1_mode,
  input  logic              fsync,
  output logic [POS_W-1:0]  pos_q,
  output logic              in_slot,
  output logic              slot_first,
  output logic [SLOT_W-1:0] slot,
  output logic [BIT_W-1:0]  bitn
);
  logic [POS_W-1:0] pos_cur;
  slot_loc_t        loc;

  always_comb begin
    if (fsync)                              pos_cur = '0;
    else if (pos_q >= frame_last(e1_mode))  pos_cur = '0;
    else                                    pos_cur = pos_q + POS_W'(1);
    loc        = locate(pos_cur, e1_mode);
    in_slot    = loc.valid;
    slot       = loc.slot;
    bitn       = loc.bitn;
    slot_first = loc.valid && (loc.bitn == '0);
  end

  // Reset value forces the first bit after reset to position 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '1;
    else        pos_q <= pos_cur;
  end
endmodule

// File: rtl/icu_subst.sv
module icu_subst
  import icu_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tx_in,
  input  logic                         in_slot,
  input  logic                         slot_first,
  input  logic [SLOT_W-1:0]            slot,
  input  logic [BIT_W-1:0]             bitn,
  input  logic [SLOTS-1:0][CODE_W-1:0] tx_codes,
  input  logic [SLOTS-1:0]             tx_enables,
  output logic                         tx_out,
  output logic                         sub_fire,
  output logic [CODE_W-1:0]            code_q
);
  logic              en_q;
  logic [CODE_W-1:0] cur_code;
  logic              cur_en;

  always_comb begin
    cur_code = slot_first ? tx_codes[slot]   : code_q;
    cur_en   = slot_first ? tx_enables[slot] : en_q;
    sub_fire = in_slot && cur_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      en_q   <= 1'b0;
      tx_out <= 1'b0;
    end else begin
      if (slot_first) begin
        code_q <= tx_codes[slot];
        en_q   <= tx_enables[slot];
      end
      tx_out <= sub_fire ? cur_code[~bitn] : tx_in;
    end
  end
endmodule

// File: rtl/idle_code_inserter.sv
module idle_code_inserter
  import icu_pkg::*;
#(
  parameter logic [7:0] ADDR_BASE = 8'h7E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       e1_mode,
  input  logic       host_we,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       fsync,
  input  logic       tx_in,
  output logic       tx_out
);
  logic [SLOTS-1:0][CODE_W-1:0] tx_codes;
  logic [SLOTS-1:0]             tx_enables;
  logic [POS_W-1:0]             pos_q;
  logic                         in_slot;
  logic                         slot_first;
  logic [SLOT_W-1:0]            slot;
  logic [BIT_W-1:0]             bitn;
  logic                         sub_fire;
  logic [CODE_W-1:0]            code_q;

  icu_regs #(.ADDR_BASE(ADDR_BASE)) regs_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_codes(tx_codes), .tx_enables(tx_enables)
  );

  icu_framer framer_i (
    .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .fsync(fsync),
    .pos_q(pos_q), .in_slot(in_slot), .slot_first(slot_first),
    .slot(slot), .bitn(bitn)
  );

  icu_subst subst_i (
    .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .in_slot(in_slot),
    .slot_first(slot_first), .slot(slot), .bitn(bitn),
    .tx_codes(tx_codes), .tx_enables(tx_enables),
    .tx_out(tx_out), .sub_fire(sub_fire), .code_q(code_q)
  );
endmodule

// File: rtl/icu_checker.sv
module icu_checker
  import icu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              e1_mode,
  input logic              fsync,
  input logic              tx_in,
  input logic              tx_out,
  input logic              sub_fire,
  input logic              slot_first,
  input logic              in_slot,
  input logic [SLOT_W-1:0] slot,
  input logic [POS_W-1:0]  pos_q,
  input logic [CODE_W-1:0] code_q
);
  p_pass_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_fire |=> tx_out == $past(tx_in));

  p_framing_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!e1_mode && !in_slot) |=> tx_out == $past(tx_in));

  p_t1_slot_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!e1_mode && in_slot) |-> slot < SLOT_W'(T1_SLOTS));

  p_code_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_first |=> $stable(code_q));

  p_e1_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_mode && !fsync && pos_q == POS_W'(255)) |=> pos_q == '0);

  p_pos_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && pos_q < POS_W'(192)) |=> pos_q == $past(pos_q) + POS_W'(1));

  p_sync_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> pos_q == '0);
endmodule

bind idle_code_inserter icu_checker chk_i (
  .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .fsync(fsync),
  .tx_in(tx_in), .tx_out(tx_out), .sub_fire(sub_fire),
  .slot_first(slot_first), .in_slot(in_slot), .slot(slot),
  .pos_q(pos_q), .code_q(code_q)
);

// File: tb/idle_code_inserter_tb_top.sv
module idle_code_inserter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       e1_mode = 1'b1;
  logic       host_we = 1'b0;
  logic [7:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       fsync = 1'b0;
  logic       tx_in = 1'b0;
  logic       tx_out;

  int checks = 0;
  int errors = 0;

  logic [7:0]  sh_mem [64];
  logic [31:0] sh_en;
  logic [7:0]  sh_ctl;
  logic [7:0]  snap_code;
  logic        snap_en;
  logic        pend = 1'b0;
  logic        pend_exp;
  string       pend_req;

  always #10 clk = ~clk;

  idle_code_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fsync(fsync), .tx_in(tx_in), .tx_out(tx_out)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sh_apply(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h7E) sh_ctl = d;
    else if (a == 8'h7F) begin
      if (sh_ctl[6] || sh_ctl[7]) begin
        for (int i = 0; i < 32; i++) begin
          if (sh_ctl[6]) sh_mem[i] = d;
          if (sh_ctl[7]) sh_mem[32+i] = d;
        end
      end else sh_mem[sh_ctl[5:0]] = d;
    end else if (a >= 8'h80 && a <= 8'h83) sh_en[8*(a-8'h80) +: 8] = d;
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'h7E) return sh_ctl;
    if (a == 8'h7F) return sh_mem[sh_ctl[5:0]];
    if (a >= 8'h80 && a <= 8'h83) return sh_en[8*(a-8'h80) +: 8];
    return 8'h00;
  endfunction

  task automatic check_pending();
    if (pend) begin
      check({7'd0, tx_out}, {7'd0, pend_exp}, pend_req);
      pend = 1'b0;
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    sh_apply(a, d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_check(input logic [7:0] a, input string req);
    @(negedge clk);
    host_addr = a;
    #1;
    check(host_rdata, exp_read(a), req);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 64; i++) begin
      host_write(8'h7E, 8'(i));
      host_check(8'h7F, req);
    end
  endtask

  // One frame of stream; optional host write on bit hook_pos.
  task automatic run_frame(input bit e1, input bit sync, input int hook_pos,
                           input logic [7:0] ha, input logic [7:0] hd, input string req);
    int len;
    len = e1 ? 256 : 193;
    for (int p = 0; p < len; p++) begin
      int rel, s, b;
      logic ex;
      @(negedge clk);
      check_pending();
      host_we = 1'b0;
      e1_mode = e1;
      fsync = sync && (p == 0);
      tx_in = 1'($urandom);
      if (!e1 && p == 0) ex = tx_in;
      else begin
        rel = e1 ? p : p - 1;
        s = rel / 8;
        b = rel % 8;
        if (b == 0) begin
          snap_code = sh_mem[s];
          snap_en = sh_en[s];
        end
        ex = snap_en ? snap_code[7-b] : tx_in;
      end
      pend = 1'b1; pend_exp = ex; pend_req = req;
      if (p == hook_pos) begin
        host_we = 1'b1; host_addr = ha; host_wdata = hd;
        sh_apply(ha, hd);
      end
    end
  endtask

  task automatic flush();
    @(negedge clk);
    check_pending();
    host_we = 1'b0;
    fsync = 1'b0;
    tx_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) sh_mem[i] = '0;
    sh_en = '0;
    sh_ctl = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check({7'd0, tx_out}, 8'd0, "R1 tx_out");
    rst_n = 1'b1;
    host_check(8'h7E, "R1 ctl");
    host_check(8'h7F, "R1 entry0");
    for (int g = 0; g < 4; g++) host_check(8'h80 + 8'(g), "R1 enable");

    // R2: indirect write of every entry, then read back
    for (int i = 0; i < 64; i++) begin
      host_write(8'h7E, 8'(i));
      host_write(8'h7F, 8'((i * 37 + 11) & 8'hFF));
    end
    host_check(8'h7E, "R2 ctl readback");
    read_all("R2 entry readback");

    // R5: enable registers
    host_write(8'h80, 8'hA5);
    host_write(8'h81, 8'h3C);
    host_write(8'h82, 8'hF0);
    host_write(8'h83, 8'h81);
    for (int g = 0; g < 4; g++) host_check(8'h80 + 8'(g), "R5 enable readback");

    // R6 R7 R9: E1 frame with sync, then a frame that wraps without sync
    run_frame(1'b1, 1'b1, -1, 8'h00, 8'h00, "R6 R9 e1 frame");
    run_frame(1'b1, 1'b0, -1, 8'h00, 8'h00, "R7 e1 wrap");
    flush();

    // R8: T1 frames, channel 24 and channels 25..32 enabled
    host_write(8'h82, 8'h80);
    host_write(8'h83, 8'hFF);
    run_frame(1'b0, 1'b1, -1, 8'h00, 8'h00, "R8 t1 frame");
    run_frame(1'b0, 1'b0, -1, 8'h00, 8'h00, "R8 t1 wrap");
    flush();

    // R10: code write mid-slot (slot 5, bit 3), enable clear mid-slot (slot 0, bit 4)
    host_write(8'h80, 8'h21);
    host_write(8'h7E, 8'h05);
    run_frame(1'b1, 1'b1, 5*8+3, 8'h7F, 8'h5A, "R10 code mid slot");
    run_frame(1'b1, 1'b0, 4, 8'h80, 8'h20, "R10 enable mid slot");
    run_frame(1'b0, 1'b1, 5*8+1+6, 8'h7F, 8'hC6, "R10 t1 code mid slot");
    flush();

    // R3: transmit broadcast
    host_write(8'h7E, 8'h45);
    host_write(8'h7F, 8'h3C);
    host_write(8'h7E, 8'h00);
    read_all("R3 tx broadcast");
    for (int g = 0; g < 4; g++) host_write(8'h80 + 8'(g), 8'hFF);
    run_frame(1'b1, 1'b1, -1, 8'h00, 8'h00, "R3 R6 all slots");
    flush();

    // R4: receive broadcast
    host_write(8'h7E, 8'hA0);
    host_write(8'h7F, 8'hC3);
    host_check(8'h7E, "R2 ctl with flag");
    host_write(8'h7E, 8'h00);
    read_all("R4 rx broadcast");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule